// File: doc/BRIEF.md
# Parity-Protected Read-Only Cache with Miss-on-Error Recovery

This block is a small direct-mapped, read-only cache that sits in front of a slow backing memory such as flash. Each data word is stored with one even-parity bit per byte, and each set's tag and valid bit share one more parity bit. Every lookup checks that parity. When the check finds a mismatch and recovery is enabled, the lookup is handled as a miss. The line is fetched again from backing memory with fresh parity, and the requester gets correct data without software having to act.

A refill requests the line's words starting at the requested word and wraps around the line. The requester is stalled only until that first word comes back, and the rest of the line fills in the background. A small register port controls three things: whether parity is checked, whether a parity error forces a miss, and whether errors are recorded. Recording is kept separate from detection and recovery. The sticky error flags and the captured failing address change only while recording is on. A one-shot inject control stores inverted parity on the next refill, so the error paths can be exercised. A global invalidate input clears every line in one cycle.

Top module: `pcache`

## Requirements
- R1: Out of reset, CTRL (address 0) reads 0x3: bit0 is the check enable, bit1 is the miss-on-error enable, and bits 2 and 3 are zero. REPORT (address 1) reads 0 and STATUS (address 2) reads 0. Every line is invalid, so the first access to any address misses.
- R2: A lookup that hits returns the stored word with rsp_valid in the same cycle as the request, with no memory read. A miss reads all LINE_WORDS words of the line from memory, and mem_addr is held while a read waits for mem_rvalid.
- R3: A refill first reads the requested word, then the following words, wrapping within the line. The response is given in the cycle that first word returns.
- R4: A refill stores freshly generated even parity for each byte and for the tag with its valid bit. After a clean refill, the line hits with no parity error.
- R5: When checking and miss-on-error are both on and a lookup finds a data or tag parity error, no hit is given. The line is reloaded from memory and the correct word is returned.
- R6: Recording is off out of reset. While it is off, errors are still detected and recovered, but STATUS and ERRADDR do not change.
- R7: While REPORT bit0 is 1, a data parity error sets STATUS bit0 and a tag parity error sets STATUS bit1. The flags are sticky and are cleared by writing 1 to them.
- R8: ERRADDR (address 3) captures the request address of an error recorded while STATUS is all clear. It holds that address until both flags have been cleared.
- R9: With CTRL bit0 at 0, no parity check is made. A corrupted line hits, and no flag is set.
- R10: With checking on and CTRL bit1 at 0, a lookup on a line with a parity error hits and returns the stored word without a refill. The error is still flagged if recording is on.
- R11: CTRL bit2 inverts every byte parity bit, and CTRL bit3 inverts the tag parity bit, on the next refill. Both bits clear themselves when that refill completes.
- R12: A one-cycle pulse on inval clears all valid bits and recomputes the tag parity to match. Later accesses miss without recording any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval | input | 1 | Global invalidate pulse |
| cpu_req | input | 1 | Read request, held until rsp_valid |
| cpu_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DATA_W | Read data |
| mem_rd | output | 1 | Backing memory read request, held until mem_rvalid |
| mem_addr | output | ADDR_W | Backing memory word address |
| mem_rvalid | input | 1 | Backing memory data valid |
| mem_rdata | input | DATA_W | Backing memory data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The hardest case to reach from the ports is a line whose stored parity disagrees with its contents, because every refill writes correct parity. The bench arms the one-shot inject bits, takes a miss so that the poisoned line is stored, and then reads the same line again. The tag case and the data case are each poisoned this way. A hit is told apart from a silent refill by the response latency and by counting memory words delivered. The same poisoned line is then read with each combination of check, recovery and recording controls.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } pc_state_e;

    localparam logic [1:0] RA_CTRL   = 2'd0;
    localparam logic [1:0] RA_REPORT = 2'd1;
    localparam logic [1:0] RA_STATUS = 2'd2;
    localparam logic [1:0] RA_ERRADR = 2'd3;
endpackage

// File: rtl/pcache_par.sv
module pcache_par #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   data,
    output logic [DATA_W/8-1:0] par
);
    localparam int NBYTE = DATA_W / 8;

    // even parity: one bit per byte lane
    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign par[g] = ^data[8*g +: 8];
    end
endmodule

// File: rtl/pcache_csr.sv
module pcache_csr
    import pcache_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [3:0]        reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              det_data,
    input  logic              det_tag,
    input  logic [ADDR_W-1:0] det_addr,
    input  logic              fill_done,
    output logic              chk_en,
    output logic              moe_en,
    output logic              poison_data,
    output logic              poison_tag
);
    typedef struct packed {
        logic              chk;
        logic              moe;
        logic              pdat;
        logic              ptag;
        logic              rep;
        logic [1:0]        flg;
        logic [ADDR_W-1:0] ea;
    } csr_t;

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (fill_done) begin
            csr_d.pdat = 1'b0;
            csr_d.ptag = 1'b0;
        end
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL:   {csr_d.ptag, csr_d.pdat, csr_d.moe, csr_d.chk} = reg_wdata;
                RA_REPORT: csr_d.rep = reg_wdata[0];
                RA_STATUS: csr_d.flg = csr_q.flg & ~reg_wdata[1:0];
                default:   ;
            endcase
        end
        if (csr_q.rep) begin
            if (det_data) csr_d.flg[0] = 1'b1;
            if (det_tag)  csr_d.flg[1] = 1'b1;
            if ((det_data || det_tag) && csr_q.flg == 2'b00) csr_d.ea = det_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q     <= '0;
            csr_q.chk <= 1'b1;
            csr_q.moe <= 1'b1;
        end else begin
            csr_q <= csr_d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = {28'd0, csr_q.ptag, csr_q.pdat, csr_q.moe, csr_q.chk};
            RA_REPORT: reg_rdata = {31'd0, csr_q.rep};
            RA_STATUS: reg_rdata = {30'd0, csr_q.flg};
            default:   reg_rdata = {{(32-ADDR_W){1'b0}}, csr_q.ea};
        endcase
    end

    assign chk_en      = csr_q.chk;
    assign moe_en      = csr_q.moe;
    assign poison_data = csr_q.pdat;
    assign poison_tag  = csr_q.ptag;

    a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_q.rep && !reg_wr) |=> $stable(csr_q.flg));
    a_r8_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q.flg != 2'b00 && !reg_wr) |=> $stable(csr_q.ea));
    a_r11_inject_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && !reg_wr) |=> (!csr_q.pdat && !csr_q.ptag));
endmodule

// File: rtl/pcache.sv
module pcache
    import pcache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int SETS       = 8,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [3:0]        reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int NBYTE  = DATA_W / 8;
    localparam int WORDS  = SETS * LINE_WORDS;

    typedef struct packed {
        pc_state_e                     st;
        logic [OFF_W-1:0]              cnt;
        logic [OFF_W-1:0]              crit;
        logic [LINE_W-1:0]             line;
        logic [WORDS-1:0][DATA_W-1:0]  data;
        logic [WORDS-1:0][NBYTE-1:0]   dpar;
        logic [SETS-1:0][TAG_W-1:0]    tag;
        logic [SETS-1:0]               val;
        logic [SETS-1:0]               tpar;
    } core_t;

    core_t core_d, core_q;

    logic chk_en, moe_en, poison_data, poison_tag, fill_done;

    // lookup decode
    logic [TAG_W-1:0]       req_tag;
    logic [IDX_W-1:0]       req_idx;
    logic [OFF_W+IDX_W-1:0] req_word;
    logic [NBYTE-1:0]       look_par, fill_par;
    logic                   lookup, tag_match, tag_perr, data_perr, perr, force_miss, hit;
    logic [OFF_W-1:0]       fill_off;
    logic [OFF_W+IDX_W-1:0] fill_word;

    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = cpu_addr[OFF_W +: IDX_W];
    assign req_word = cpu_addr[OFF_W+IDX_W-1:0];
    assign fill_off  = core_q.crit + core_q.cnt;
    assign fill_word = {core_q.line[IDX_W-1:0], fill_off};

    pcache_par #(.DATA_W(DATA_W)) u_look_par (.data(core_q.data[req_word]), .par(look_par));
    pcache_par #(.DATA_W(DATA_W)) u_fill_par (.data(mem_rdata), .par(fill_par));

    assign lookup     = (core_q.st == ST_LOOKUP) && cpu_req;
    assign tag_match  = core_q.val[req_idx] && (core_q.tag[req_idx] == req_tag);
    assign tag_perr   = chk_en && (^{core_q.val[req_idx], core_q.tag[req_idx], core_q.tpar[req_idx]});
    assign data_perr  = chk_en && tag_match && (look_par != core_q.dpar[req_word]);
    assign perr       = lookup && (tag_perr || data_perr);
    assign force_miss = perr && moe_en;
    assign hit        = lookup && tag_match && !force_miss;

    always_comb begin
        core_d    = core_q;
        fill_done = 1'b0;
        if (inval) begin
            for (int s = 0; s < SETS; s++) begin
                core_d.tpar[s] = core_q.tpar[s] ^ core_q.val[s];
            end
            core_d.val = '0;
        end
        case (core_q.st)
            ST_LOOKUP: begin
                if (lookup && !hit) begin
                    core_d.st            = ST_FILL;
                    core_d.cnt           = '0;
                    core_d.crit          = cpu_addr[OFF_W-1:0];
                    core_d.line          = cpu_addr[ADDR_W-1:OFF_W];
                    core_d.val[req_idx]  = 1'b0;
                    core_d.tpar[req_idx] = ^core_q.tag[req_idx];
                end
            end
            default: begin
                if (mem_rvalid) begin
                    core_d.data[fill_word] = mem_rdata;
                    core_d.dpar[fill_word] = fill_par ^ {NBYTE{poison_data}};
                    core_d.cnt             = core_q.cnt + 1'b1;
                    if (core_q.cnt == OFF_W'(LINE_WORDS - 1)) begin
                        core_d.st  = ST_LOOKUP;
                        fill_done  = 1'b1;
                        core_d.tag[core_q.line[IDX_W-1:0]]  = core_q.line[LINE_W-1 -: TAG_W];
                        core_d.val[core_q.line[IDX_W-1:0]]  = 1'b1;
                        core_d.tpar[core_q.line[IDX_W-1:0]] =
                            (^{1'b1, core_q.line[LINE_W-1 -: TAG_W]}) ^ poison_tag;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign mem_rd    = (core_q.st == ST_FILL);
    assign mem_addr  = {core_q.line, fill_off};
    assign rsp_valid = hit || (mem_rd && mem_rvalid && core_q.cnt == '0);
    assign rsp_data  = hit ? core_q.data[req_word] : mem_rdata;

    pcache_csr #(.ADDR_W(ADDR_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .det_data(lookup && data_perr), .det_tag(lookup && tag_perr), .det_addr(cpu_addr),
        .fill_done(fill_done),
        .chk_en(chk_en), .moe_en(moe_en), .poison_data(poison_data), .poison_tag(poison_tag)
    );

    a_r3_critical_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> (mem_addr == $past(cpu_addr)));
    a_r2_mem_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));
    a_r5_error_refills: assert property (@(posedge clk) disable iff (!rst_n)
        (perr && moe_en) |=> mem_rd);
    a_r10_error_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup && tag_match && !moe_en) |-> rsp_valid);
    a_r12_inval_all: assert property (@(posedge clk) disable iff (!rst_n)
        (inval && !fill_done) |=> (core_q.val == '0));
endmodule

// File: tb/sim_pcache.sv
module sim_pcache;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inval = 1'b0;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [3:0]    reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int checks = 0;
    int failures = 0;
    int nwords = 0;
    logic [AW-1:0] first_addr = '0;
    logic rd_prev = 1'b0;

    always #4 clk = ~clk;

    pcache u0 (
        .clk(clk), .rst_n(rst_n), .inval(inval),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [DW-1:0] mdat(input logic [AW-1:0] a);
        return {~a, a};
    endfunction

    // backing memory: one word per read, returned the cycle after the request
    always @(posedge clk) begin
        rd_prev <= mem_rd;
        if (mem_rd && !rd_prev) first_addr <= mem_addr;
        if (mem_rvalid) nwords <= nwords + 1;
        if (mem_rd && !mem_rvalid) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mdat(mem_addr);
        end else begin
            mem_rvalid <= 1'b0;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, "register", reg_rdata, exp);
    endtask

    // miss: expect LINE_WORDS words, critical word first, response two cycles in
    task automatic access(input logic [AW-1:0] a, input bit miss, input string req);
        int lat = 0;
        int n0;
        logic [DW-1:0] got;
        @(negedge clk);
        n0 = nwords;
        cpu_req = 1'b1; cpu_addr = a;
        #1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
            #1;
        end
        got = rsp_data;
        @(negedge clk);
        cpu_req = 1'b0;
        repeat (12) @(negedge clk);
        chk(got == mdat(a), req, "data", got, mdat(a));
        chk((nwords - n0) == (miss ? 4 : 0), req, "words fetched", nwords - n0, miss ? 4 : 0);
        chk(lat == (miss ? 2 : 0), req, "latency", lat, miss ? 2 : 0);
        if (miss) chk(first_addr == a, "R3", "first word address", first_addr, a);
    endtask

    task automatic t_reset;
        reg_check(2'd0, 32'h3, "R1");
        reg_check(2'd1, 32'h0, "R1");
        reg_check(2'd2, 32'h0, "R1");
        access(16'h0040, 1'b1, "R1");
    endtask

    task automatic t_hits;
        access(16'h0041, 1'b0, "R2");
        access(16'h0046, 1'b1, "R3");
        access(16'h0044, 1'b0, "R3");
        access(16'h0047, 1'b0, "R3");
        access(16'h0045, 1'b0, "R4");
        access(16'h0060, 1'b1, "R2");
        access(16'h0040, 1'b1, "R2");
    endtask

    task automatic t_silent_fix;
        reg_write(2'd0, 4'h7);
        access(16'h0100, 1'b1, "R11");
        reg_check(2'd0, 32'h3, "R11");
        access(16'h0102, 1'b1, "R5");
        reg_check(2'd2, 32'h0, "R6");
        reg_check(2'd3, 32'h0, "R6");
        access(16'h0102, 1'b0, "R4");
    endtask

    task automatic t_report;
        reg_write(2'd1, 4'h1);
        reg_write(2'd0, 4'h7);
        access(16'h0200, 1'b1, "R7");
        access(16'h0201, 1'b1, "R5");
        reg_check(2'd2, 32'h1, "R7");
        reg_check(2'd3, 32'h0201, "R8");
        reg_write(2'd0, 4'hB);
        access(16'h0300, 1'b1, "R11");
        access(16'h0303, 1'b1, "R5");
        reg_check(2'd2, 32'h3, "R7");
        reg_check(2'd3, 32'h0201, "R8");
        reg_write(2'd2, 4'h1);
        reg_check(2'd2, 32'h2, "R7");
        reg_write(2'd2, 4'h2);
        reg_check(2'd2, 32'h0, "R7");
        reg_write(2'd0, 4'h7);
        access(16'h0400, 1'b1, "R8");
        access(16'h0401, 1'b1, "R8");
        reg_check(2'd3, 32'h0401, "R8");
        reg_write(2'd2, 4'h3);
    endtask

    task automatic t_moe_off;
        reg_write(2'd0, 4'h5);
        access(16'h0500, 1'b1, "R10");
        access(16'h0501, 1'b0, "R10");
        reg_check(2'd2, 32'h1, "R10");
        reg_write(2'd2, 4'h3);
    endtask

    task automatic t_check_off;
        reg_write(2'd0, 4'h0);
        access(16'h0502, 1'b0, "R9");
        reg_check(2'd2, 32'h0, "R9");
        reg_write(2'd0, 4'h3);
        access(16'h0502, 1'b1, "R5");
        reg_check(2'd2, 32'h1, "R7");
        reg_check(2'd3, 32'h0502, "R8");
        reg_write(2'd2, 4'h3);
    endtask

    task automatic t_inval;
        access(16'h0503, 1'b0, "R12");
        @(negedge clk);
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        access(16'h0503, 1'b1, "R12");
        access(16'h0041, 1'b1, "R12");
        reg_check(2'd2, 32'h0, "R12");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_hits;
        t_silent_fix;
        t_report;
        t_moe_off;
        t_check_off;
        t_inval;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule